// File: doc/BRIEF.md
# Linked-List Memory Copy Engine

This block is a memory-to-memory copy engine that takes its work from a chain of transfer records kept in memory. Software hands it the address of the first record and pulses a start input. Each record occupies four consecutive 32-bit words. The engine reads the record, then copies the requested number of bytes one word at a time. Every word is read from the source into an internal holding register and then written out to the destination. When a record's count is exhausted, the engine moves to the record named by that record's link word. It stops when the link word is zero.

The block drives one synchronous memory master port. A request stays asserted with a fixed address, direction and write data until the memory answers with ready. The engine advances only on a ready cycle, so any memory latency is tolerated. A busy output covers the whole walk of the chain. A done output is raised when the chain ends and stays up until the next accepted start.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are all 0.
- R2: A start_i pulse while idle, with a non-zero first_desc_i, makes busy_o 1 and done_o 0 on the following cycle. The first four memory accesses are then reads at first_desc_i, +4, +8 and +12. They return, in that order, the byte count, the source address, the destination address and the link word, and all four come before any data access for that record.
- R3: Each data word is moved by a read at the current source address, followed by a write of exactly the data read to the current destination address. Both addresses then advance by 4.
- R4: A record moves count>>2 words. The two low bits of the count are ignored, and no write lands past the last whole word.
- R5: A record whose count is below 4 moves no data. The next access after its fourth record read is the first read of the linked record, or the chain ends.
- R6: After a record completes with a non-zero link, the next access is a read at the link address. With a zero link, busy_o falls and done_o rises in the same cycle.
- R7: A start_i pulse while idle with first_desc_i equal to zero makes no memory access, keeps busy_o at 0 and sets done_o on the following cycle.
- R8: A start_i pulse while busy_o is 1 is ignored, and so is the pointer that comes with it.
- R9: While mem_req_o is 1 and mem_ready_i is 0, the next cycle keeps mem_req_o at 1 and keeps mem_addr_o, mem_we_o and mem_wdata_o unchanged.
- R10: An accepted start clears a done_o left over from the previous chain on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin a chain |
| first_desc_i | input | DW | Byte address of the first record |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | Last chain reached its zero link |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | DW | Byte address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid when mem_ready_i is 1 |
| mem_ready_i | input | 1 | Access completes on this cycle |

## Verification
The bench builds the engine with its default 32-bit word and address width, against a 256-word memory model whose ready latency is set per test from 0 to 3 cycles. Zero latency covers back-to-back accesses. The longer latencies keep requests pending for several cycles, which exposes the hold rule and makes room for a start pulse to arrive mid-chain. Chains of three records, a zero-count record and a count with stray low bits reach the link-following and rounding paths within a few dozen cycles each.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECIDE,
        ST_READ,
        ST_WRITE,
        ST_NEXT
    } dma_state_e;

    // Record layout: word index of each field inside a record
    localparam logic [1:0] FLD_COUNT = 2'd0;
    localparam logic [1:0] FLD_SRC   = 2'd1;
    localparam logic [1:0] FLD_DST   = 2'd2;
    localparam logic [1:0] FLD_LINK  = 2'd3;

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          take_i,
    input  logic [DW-1:0] word_i,
    output logic [1:0]    idx_o,
    output logic          last_o,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] src_o,
    output logic [DW-1:0] dst_o,
    output logic [DW-1:0] link_o
);
    import dma_chain_pkg::*;

    typedef struct packed {
        logic [1:0]    idx;
        logic [DW-1:0] count;
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] link;
    } fetch_t;

    fetch_t fetch_d, fetch_q;

    always_comb begin
        fetch_d = fetch_q;
        if (restart_i) begin
            fetch_d.idx = FLD_COUNT;
        end else if (take_i) begin
            case (fetch_q.idx)
                FLD_COUNT: fetch_d.count = word_i;
                FLD_SRC:   fetch_d.src   = word_i;
                FLD_DST:   fetch_d.dst   = word_i;
                default:   fetch_d.link  = word_i;
            endcase
            fetch_d.idx = fetch_q.idx + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_q <= '0;
        end else begin
            fetch_q <= fetch_d;
        end
    end

    assign idx_o   = fetch_q.idx;
    assign last_o  = (fetch_q.idx == FLD_LINK);
    assign count_o = fetch_q.count;
    assign src_o   = fetch_q.src;
    assign dst_o   = fetch_q.dst;
    assign link_o  = fetch_q.link;

endmodule

// File: rtl/dma_word_mover.sv
module dma_word_mover #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] words_i,
    input  logic          rd_take_i,
    input  logic          wr_take_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] src_o,
    output logic [DW-1:0] dst_o,
    output logic [DW-1:0] data_o,
    output logic          last_o
);
    localparam int unsigned   STEP     = DW / 8;
    localparam logic [DW-1:0] STEP_VEC = DW'(STEP);

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] rem;
        logic [DW-1:0] hold;
    } mover_t;

    mover_t mv_d, mv_q;

    always_comb begin
        mv_d = mv_q;
        if (load_i) begin
            mv_d.src = src_i;
            mv_d.dst = dst_i;
            mv_d.rem = words_i;
        end else begin
            if (rd_take_i) begin
                mv_d.hold = word_i;
            end
            if (wr_take_i) begin
                mv_d.src = mv_q.src + STEP_VEC;
                mv_d.dst = mv_q.dst + STEP_VEC;
                mv_d.rem = mv_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv_q <= '0;
        end else begin
            mv_q <= mv_d;
        end
    end

    assign src_o  = mv_q.src;
    assign dst_o  = mv_q.dst;
    assign data_o = mv_q.hold;
    assign last_o = (mv_q.rem == DW'(1));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] first_desc_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [DW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_ready_i
);
    import dma_chain_pkg::*;

    localparam int unsigned SH = $clog2(DW / 8);

    typedef struct packed {
        dma_state_e    state;
        logic [DW-1:0] ptr;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          f_restart, f_take, f_last;
    logic [1:0]    f_idx;
    logic [DW-1:0] f_count, f_src, f_dst, f_link;
    logic          m_load, m_rd_take, m_wr_take, m_last;
    logic [DW-1:0] m_src, m_dst, m_data;
    logic [DW-1:0] words_w;

    assign words_w = f_count >> SH;

    dma_desc_fetch #(.DW(DW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (f_restart),
        .take_i    (f_take),
        .word_i    (mem_rdata_i),
        .idx_o     (f_idx),
        .last_o    (f_last),
        .count_o   (f_count),
        .src_o     (f_src),
        .dst_o     (f_dst),
        .link_o    (f_link)
    );

    dma_word_mover #(.DW(DW)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (m_load),
        .src_i     (f_src),
        .dst_i     (f_dst),
        .words_i   (words_w),
        .rd_take_i (m_rd_take),
        .wr_take_i (m_wr_take),
        .word_i    (mem_rdata_i),
        .src_o     (m_src),
        .dst_o     (m_dst),
        .data_o    (m_data),
        .last_o    (m_last)
    );

    always_comb begin
        ctl_d       = ctl_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = m_data;
        f_restart   = 1'b0;
        f_take      = 1'b0;
        m_load      = 1'b0;
        m_rd_take   = 1'b0;
        m_wr_take   = 1'b0;

        case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (first_desc_i == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.done  = 1'b0;
                        ctl_d.ptr   = first_desc_i;
                        ctl_d.state = ST_FETCH;
                        f_restart   = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctl_q.ptr + (DW'(f_idx) << SH);
                if (mem_ready_i) begin
                    f_take = 1'b1;
                    if (f_last) begin
                        ctl_d.state = ST_DECIDE;
                    end
                end
            end
            ST_DECIDE: begin
                m_load = 1'b1;
                if (words_w == '0) begin
                    ctl_d.state = ST_NEXT;
                end else begin
                    ctl_d.state = ST_READ;
                end
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = m_src;
                if (mem_ready_i) begin
                    m_rd_take   = 1'b1;
                    ctl_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = m_dst;
                if (mem_ready_i) begin
                    m_wr_take = 1'b1;
                    if (m_last) begin
                        ctl_d.state = ST_NEXT;
                    end else begin
                        ctl_d.state = ST_READ;
                    end
                end
            end
            ST_NEXT: begin
                if (f_link == '0) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.ptr   = f_link;
                    ctl_d.state = ST_FETCH;
                    f_restart   = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, ptr: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q.state != ST_IDLE);
    assign done_o = ctl_q.done;

endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [DW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic [DW-1:0] mem_rdata_i,
    input logic          mem_ready_i
);
    logic [DW-1:0] last_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_rd_q <= '0;
        end else if (mem_req_o && !mem_we_o && mem_ready_i) begin
            last_rd_q <= mem_rdata_i;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                         && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R3
    wdata_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_wdata_o == last_rd_q));

    // R6
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

    // R2
    busy_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

endmodule

bind dma_chain_engine dma_chain_engine_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i)
);

// File: tb/dma_chain_engine_bench.sv
module dma_chain_engine_bench;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] first_desc_i = '0;
    logic          busy_o, done_o, mem_req_o, mem_we_o;
    logic [DW-1:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic          mem_ready_i = 1'b0;

    always #4 clk = ~clk;

    dma_chain_engine #(.DW(DW)) u_dma_chain_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .first_desc_i (first_desc_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_ready_i  (mem_ready_i)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [0:255];
    logic [31:0] log_addr [0:63];
    logic        log_we   [0:63];
    int          n_acc = 0;
    int          lat = 0;
    int          wcnt = 0;
    int          hold_viol = 0;
    logic        pend = 1'b0;
    logic [31:0] p_addr, p_wdata;
    logic        p_we;

    assign mem_rdata_i = mem[mem_addr_o[9:2]];

    always @(negedge clk) begin
        if (pend) begin
            if (!mem_req_o || mem_addr_o != p_addr || mem_we_o != p_we ||
                mem_wdata_o != p_wdata) begin
                hold_viol = hold_viol + 1;
            end
        end
        if (mem_req_o) begin
            if (wcnt >= lat) begin
                mem_ready_i = 1'b1;
                wcnt = 0;
                if (n_acc < 64) begin
                    log_addr[n_acc] = mem_addr_o;
                    log_we[n_acc]   = mem_we_o;
                end
                n_acc = n_acc + 1;
                if (mem_we_o) mem[mem_addr_o[9:2]] = mem_wdata_o;
            end else begin
                mem_ready_i = 1'b0;
                wcnt = wcnt + 1;
            end
        end else begin
            mem_ready_i = 1'b0;
            wcnt = 0;
        end
        pend    = mem_req_o && !mem_ready_i;
        p_addr  = mem_addr_o;
        p_we    = mem_we_o;
        p_wdata = mem_wdata_o;
    end

    // ---------------- check bookkeeping ----------------
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return {8'hC3, 8'(i), ~8'(i), 8'h5A};
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            if (i >= 64 && i < 128) mem[i] = pat(i);
            else                    mem[i] = 32'hDEAD0000 | 32'(i);
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] cnt,
                            input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] lnk);
        mem[at[9:2]]      = cnt;
        mem[at[9:2] + 1]  = s;
        mem[at[9:2] + 2]  = d;
        mem[at[9:2] + 3]  = lnk;
    endtask

    task automatic pulse_start(input logic [31:0] p);
        @(negedge clk);
        n_acc = 0;
        first_desc_i = p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done_o && t < 2000) begin
            @(negedge clk);
            t = t + 1;
        end
        chk(done_o, "R6 chain end timeout", 32'(done_o), 32'd1);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] nbytes;
        logic [31:0] lat;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h100, 32'h200, 32'd16, 32'd0},
        '{32'h104, 32'h240, 32'd4,  32'd1},
        '{32'h120, 32'h280, 32'd32, 32'd2},
        '{32'h130, 32'h300, 32'd13, 32'd3},
        '{32'h140, 32'h380, 32'd2,  32'd1}
    };

    initial begin
        int gw;
        gw = 0;
        while (gw < 100000) begin
            @(posedge clk);
            gw = gw + 1;
        end
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        fill_mem();
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R1 reset outputs",
            {29'd0, busy_o, done_o, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R1 after reset release",
            {29'd0, busy_o, done_o, mem_req_o}, 32'd0);

        // table walk: single record at 0x10 per vector
        foreach (VECS[v]) begin
            fill_mem();
            lat = int'(VECS[v].lat);
            n = int'(VECS[v].nbytes >> 2);
            put_desc(32'h10, VECS[v].nbytes, VECS[v].src, VECS[v].dst, 32'h0);
            pulse_start(32'h10);
            chk(busy_o && !done_o, "R2 busy after start",
                {30'd0, busy_o, done_o}, 32'd2);
            wait_done();
            chk(!busy_o, "R6 busy low at end", 32'(busy_o), 32'd0);
            chk(n_acc == 4 + 2 * n, "R4 access count", 32'(n_acc), 32'(4 + 2 * n));
            for (int i = 0; i < 4; i++) begin
                chk(log_addr[i] == 32'h10 + 32'(4 * i) && !log_we[i],
                    "R2 record read order", log_addr[i], 32'h10 + 32'(4 * i));
            end
            for (int k = 0; k < n; k++) begin
                chk(log_addr[4 + 2 * k] == VECS[v].src + 32'(4 * k) && !log_we[4 + 2 * k],
                    "R3 source read", log_addr[4 + 2 * k], VECS[v].src + 32'(4 * k));
                chk(log_addr[5 + 2 * k] == VECS[v].dst + 32'(4 * k) && log_we[5 + 2 * k],
                    "R3 dest write", log_addr[5 + 2 * k], VECS[v].dst + 32'(4 * k));
                chk(mem[VECS[v].dst[9:2] + 8'(k)] == pat(int'(VECS[v].src[9:2]) + k),
                    "R3 copied data", mem[VECS[v].dst[9:2] + 8'(k)],
                    pat(int'(VECS[v].src[9:2]) + k));
            end
            chk(mem[VECS[v].dst[9:2] + 8'(n)] == (32'hDEAD0000 | 32'(VECS[v].dst[9:2] + 8'(n))),
                "R4 no write past end", mem[VECS[v].dst[9:2] + 8'(n)],
                32'hDEAD0000 | 32'(VECS[v].dst[9:2] + 8'(n)));
        end

        // R10 + R5 + R6: three-record chain with a zero-count middle record
        fill_mem();
        lat = 1;
        put_desc(32'h20, 32'd8,  32'h160, 32'h200, 32'h40);
        put_desc(32'h40, 32'd0,  32'h170, 32'h210, 32'h60);
        put_desc(32'h60, 32'd12, 32'h180, 32'h220, 32'h0);
        chk(done_o, "R10 done left from prior chain", 32'(done_o), 32'd1);
        pulse_start(32'h20);
        chk(!done_o && busy_o, "R10 done cleared by start",
            {30'd0, busy_o, done_o}, 32'd2);
        wait_done();
        chk(n_acc == 22, "R5 chain access count", 32'(n_acc), 32'd22);
        chk(log_addr[8] == 32'h40 && !log_we[8], "R6 link followed", log_addr[8], 32'h40);
        chk(log_addr[12] == 32'h60 && !log_we[12], "R5 zero count skips data",
            log_addr[12], 32'h60);
        chk(mem[32'h220 >> 2] == pat(32'h180 >> 2), "R6 third record data",
            mem[32'h220 >> 2], pat(32'h180 >> 2));
        chk(mem[32'h210 >> 2] == (32'hDEAD0000 | 32'h84), "R5 zero count no write",
            mem[32'h210 >> 2], 32'hDEAD0000 | 32'h84);

        // R8: start while busy is ignored
        fill_mem();
        lat = 3;
        put_desc(32'h10, 32'd16, 32'h100, 32'h200, 32'h0);
        put_desc(32'h60, 32'd4,  32'h180, 32'h300, 32'h0);
        pulse_start(32'h10);
        repeat (5) @(negedge clk);
        first_desc_i = 32'h60;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk(n_acc == 12, "R8 start while busy ignored", 32'(n_acc), 32'd12);
        chk(mem[32'h300 >> 2] == (32'hDEAD0000 | 32'hC0), "R8 ignored pointer unused",
            mem[32'h300 >> 2], 32'hDEAD0000 | 32'hC0);

        // R7: null first pointer
        pulse_start(32'h0);
        chk(done_o && !busy_o, "R7 null start sets done",
            {30'd0, busy_o, done_o}, 32'd1);
        repeat (4) @(negedge clk);
        chk(n_acc == 0, "R7 no memory access", 32'(n_acc), 32'd0);

        // R9: request stability under stalls over the whole run
        chk(hold_viol == 0, "R9 request held until ready", 32'(hold_viol), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule